// File: doc/BRIEF.md
# Write-Only SMBus Slave Receiver

This block is the serial front end of a register-controlled converter on a two-wire SMBus/I2C bus. A fast system clock oversamples the clock and data lines. Each line passes through a synchronizer and a majority-free glitch filter, and the block then finds bus START, repeated START and STOP conditions. The block only receives data. It answers to its own 7-bit address and to one shared broadcast address, and it acknowledges by pulling the data line low through an open-drain enable.

Three write transactions are accepted: a quick command (address only), a send-byte transaction (address and command byte) and a write-word transaction (address, command byte, low data byte, high data byte). A one-cycle strobe marks each accepted byte on the rising clock edge of its acknowledge slot. The command register takes its value at the command acknowledge. The 16-bit data word is committed only when the high byte is acknowledged, so a transaction cut short by START or STOP keeps the command and drops the partial data. A broadcast address frame raises its own strobe and carries the frame's eighth bit out as a mode flag. Downstream logic uses this flag to release or clear latched values on several devices at once.

Top module: `smbus_wr_slave`

## Requirements
- R1: After reset the acknowledge enable is low, all strobes are low, `cmd_o` is 0 and `word_o` is 0.
- R2: An address frame whose upper seven bits equal {0100, `addr_sel_i`} (MSB first) and whose eighth bit (write flag) is 0 is acknowledged. The same address with the eighth bit 1 is not acknowledged.
- R3: An address frame whose upper seven bits are 1111110 is acknowledged whatever its eighth bit is. `bcast_stb_o` pulses once, and `bcast_mode_o` then equals that eighth bit.
- R4: An address frame that matches neither address is not acknowledged. The bytes that follow it are ignored until the next START, and the next START is served normally.
- R5: `sda_oe_o` is high only in the ninth clock of an acknowledged byte and changes only while SCL is low, so the data line stays low through the whole high phase of the acknowledge clock.
- R6: `cmd_stb_o`, `lo_stb_o` and `hi_stb_o` are one system clock wide each. Each pulses inside the acknowledge of its byte (command byte, first data byte, second data byte), with `byte_o` holding that byte. At most one strobe output is high in any cycle.
- R7: A send-byte transaction (address, one byte, STOP) loads `cmd_o` with the byte and leaves `word_o` unchanged.
- R8: A write word loads `word_o` with {second data byte, first data byte} at the second data byte's acknowledge. A START or STOP after the command acknowledge and before that point leaves `word_o` unchanged but keeps the new `cmd_o`.
- R9: A START or STOP before the command byte is acknowledged leaves `cmd_o` unchanged and raises no `cmd_stb_o`.
- R10: `stop_stb_o` pulses once for a STOP that ends a transaction whose address was acknowledged, and never for a STOP after an unacknowledged address or after a repeated START.
- R11: A pulse on SCL shorter than `FILT_LEN` system clocks is not seen as a clock edge.
- R12: A fifth byte after the second data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | SEL_BITS | Low bits of the own address |
| sda_oe_o | output | 1 | High to pull the data line low (acknowledge) |
| cmd_stb_o | output | 1 | Command byte accepted |
| lo_stb_o | output | 1 | First data byte accepted |
| hi_stb_o | output | 1 | Second data byte accepted, word committed |
| stop_stb_o | output | 1 | STOP after an acknowledged address |
| bcast_stb_o | output | 1 | Broadcast address acknowledged |
| bcast_mode_o | output | 1 | Eighth bit of the last broadcast frame |
| byte_o | output | BYTE_W | Byte that goes with the current strobe |
| cmd_o | output | BYTE_W | Committed command byte |
| word_o | output | 2*BYTE_W | Committed data word, second byte on top |

## Verification
The bench builds the block with a two-stage synchronizer, `FILT_LEN` of 3 and address select 101. A two-cycle clock glitch can then be injected below the filter threshold, and both a neighbouring address (0100000) and the one-bit-off address (0100100) act as foreign devices. Each bus bit lasts forty system clocks, which leaves room for the filter and synchronizer delay before the acknowledge must be driven. Repeated START, early STOP and over-long writes can then all be placed at exact byte boundaries.

// File: rtl/smbus_wr_pkg.sv
package smbus_wr_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [1:0] {
      S_IDLE,
      S_RECV,
      S_ACK
   } rx_state_t;

   typedef enum logic [2:0] {
      F_ADDR,
      F_CMD,
      F_LO,
      F_HI,
      F_DONE,
      F_BCAST
   } frame_t;

   function automatic frame_t next_frame(input frame_t f);
      case (f)
         F_ADDR:  return F_CMD;
         F_CMD:   return F_LO;
         F_LO:    return F_HI;
         default: return F_DONE;
      endcase
   endfunction
endpackage

// File: rtl/smbus_line_cond.sv
module smbus_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               line_o <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&hist_q)       line_o <= 1'b1;
               else if (~|hist_q) line_o <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/smbus_bus_events.sv
module smbus_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f_i,
   input  logic sda_f_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f_i;
         sda_q <= sda_f_i;
      end
   end

   always_comb begin
      scl_rise_o = scl_f_i & ~scl_q;
      scl_fall_o = ~scl_f_i & scl_q;
      start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
      stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
   end
endmodule

// File: rtl/smbus_rx_fsm.sv
module smbus_rx_fsm
   import smbus_wr_pkg::*;
#(
   parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'b1111110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_lvl_i,
   input  logic                sda_lvl_i,
   input  logic                scl_rise_i,
   input  logic                scl_fall_i,
   input  logic                start_i,
   input  logic                stop_i,
   input  logic [ADDR_W-1:0]   own_addr_i,
   output logic                sda_oe_o,
   output logic                cmd_stb_o,
   output logic                lo_stb_o,
   output logic                hi_stb_o,
   output logic                stop_stb_o,
   output logic                bcast_stb_o,
   output logic                bcast_mode_o,
   output logic [BYTE_W-1:0]   byte_o,
   output logic [BYTE_W-1:0]   cmd_o,
   output logic [2*BYTE_W-1:0] word_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   rx_state_t         state_q;
   frame_t            frame_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] lo_hold_q;
   logic              addressed_q;
   logic              own_hit, bc_hit;

   always_comb begin
      own_hit = (shreg_q[BYTE_W-1:1] == own_addr_i) && !shreg_q[0];
      bc_hit  = (shreg_q[BYTE_W-1:1] == BCAST_ADDR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         frame_q      <= F_ADDR;
         bit_cnt_q    <= '0;
         shreg_q      <= '0;
         lo_hold_q    <= '0;
         addressed_q  <= 1'b0;
         sda_oe_o     <= 1'b0;
         cmd_stb_o    <= 1'b0;
         lo_stb_o     <= 1'b0;
         hi_stb_o     <= 1'b0;
         stop_stb_o   <= 1'b0;
         bcast_stb_o  <= 1'b0;
         bcast_mode_o <= 1'b0;
         byte_o       <= '0;
         cmd_o        <= '0;
         word_o       <= '0;
      end else begin
         cmd_stb_o   <= 1'b0;
         lo_stb_o    <= 1'b0;
         hi_stb_o    <= 1'b0;
         stop_stb_o  <= 1'b0;
         bcast_stb_o <= 1'b0;
         if (start_i) begin
            state_q     <= S_RECV;
            frame_q     <= F_ADDR;
            bit_cnt_q   <= '0;
            addressed_q <= 1'b0;
            sda_oe_o    <= 1'b0;
         end else if (stop_i) begin
            stop_stb_o  <= addressed_q;
            state_q     <= S_IDLE;
            addressed_q <= 1'b0;
            sda_oe_o    <= 1'b0;
         end else begin
            case (state_q)
               S_RECV: begin
                  if (scl_rise_i && bit_cnt_q != FULL) begin
                     shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else if (scl_fall_i && bit_cnt_q == FULL) begin
                     bit_cnt_q <= '0;
                     case (frame_q)
                        F_ADDR: begin
                           if (own_hit) begin
                              state_q     <= S_ACK;
                              sda_oe_o    <= 1'b1;
                              addressed_q <= 1'b1;
                           end else if (bc_hit) begin
                              state_q     <= S_ACK;
                              frame_q     <= F_BCAST;
                              sda_oe_o    <= 1'b1;
                              addressed_q <= 1'b1;
                           end else begin
                              state_q <= S_IDLE;
                           end
                        end
                        F_CMD, F_LO, F_HI: begin
                           state_q  <= S_ACK;
                           sda_oe_o <= 1'b1;
                        end
                        default: state_q <= S_IDLE;
                     endcase
                  end
               end
               S_ACK: begin
                  if (scl_rise_i) begin
                     case (frame_q)
                        F_CMD: begin
                           cmd_o     <= shreg_q;
                           byte_o    <= shreg_q;
                           cmd_stb_o <= 1'b1;
                        end
                        F_LO: begin
                           lo_hold_q <= shreg_q;
                           byte_o    <= shreg_q;
                           lo_stb_o  <= 1'b1;
                        end
                        F_HI: begin
                           word_o   <= {shreg_q, lo_hold_q};
                           byte_o   <= shreg_q;
                           hi_stb_o <= 1'b1;
                        end
                        F_BCAST: begin
                           bcast_mode_o <= shreg_q[0];
                           bcast_stb_o  <= 1'b1;
                        end
                        default: ;
                     endcase
                  end else if (scl_fall_i) begin
                     sda_oe_o <= 1'b0;
                     if (frame_q == F_BCAST) begin
                        state_q <= S_IDLE;
                     end else begin
                        state_q <= S_RECV;
                        frame_q <= next_frame(frame_q);
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R5: the acknowledge drive moves only while the filtered clock is low
   a_r5_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_lvl_i);

   // R6: at most one strobe per cycle
   a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_stb_o, lo_stb_o, hi_stb_o, bcast_stb_o, stop_stb_o}));

   // R6: byte strobes fall inside the driven acknowledge slot
   a_r6_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o || lo_stb_o || hi_stb_o) |-> sda_oe_o);

   // R6: byte strobes last a single cycle
   a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o || lo_stb_o || hi_stb_o) |=> !(cmd_stb_o || lo_stb_o || hi_stb_o));

   // R8: the data word changes only together with the second data strobe
   a_r8_word_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_o) |-> hi_stb_o);

   // R9: the command changes only together with its strobe
   a_r9_cmd_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_o) |-> cmd_stb_o);

   // R10: the stop strobe follows a detected STOP
   a_r10_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb_o |-> $past(stop_i));
endmodule

// File: rtl/smbus_wr_slave.sv
module smbus_wr_slave
   import smbus_wr_pkg::*;
#(
   parameter int                       SYNC_STAGES = 2,
   parameter int                       FILT_LEN    = 3,
   parameter int                       SEL_BITS    = 3,
   parameter logic [ADDR_W-SEL_BITS-1:0] ADDR_FIXED = 4'b0100,
   parameter logic [ADDR_W-1:0]        BCAST_ADDR  = 7'b1111110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   input  logic [SEL_BITS-1:0] addr_sel_i,
   output logic                sda_oe_o,
   output logic                cmd_stb_o,
   output logic                lo_stb_o,
   output logic                hi_stb_o,
   output logic                stop_stb_o,
   output logic                bcast_stb_o,
   output logic                bcast_mode_o,
   output logic [BYTE_W-1:0]   byte_o,
   output logic [BYTE_W-1:0]   cmd_o,
   output logic [2*BYTE_W-1:0] word_o
);
   localparam int NLINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (SEL_BITS < 1 || SEL_BITS >= ADDR_W) begin : g_bad_sel
         $error("SEL_BITS must lie between 1 and ADDR_W-1");
      end
   endgenerate

   logic [NLINES-1:0] raw_lines, filt_lines;
   logic scl_rise, scl_fall, bus_start, bus_stop;
   logic [ADDR_W-1:0] own_addr;

   assign raw_lines = {sda_i, scl_i};
   assign own_addr  = {ADDR_FIXED, addr_sel_i};

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         smbus_line_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
         ) i_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
         );
      end
   endgenerate

   smbus_bus_events i_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f_i   (filt_lines[0]),
      .sda_f_i   (filt_lines[1]),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (bus_start),
      .stop_o    (bus_stop)
   );

   smbus_rx_fsm #(
      .BCAST_ADDR(BCAST_ADDR)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_lvl_i   (filt_lines[0]),
      .sda_lvl_i   (filt_lines[1]),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (bus_start),
      .stop_i      (bus_stop),
      .own_addr_i  (own_addr),
      .sda_oe_o    (sda_oe_o),
      .cmd_stb_o   (cmd_stb_o),
      .lo_stb_o    (lo_stb_o),
      .hi_stb_o    (hi_stb_o),
      .stop_stb_o  (stop_stb_o),
      .bcast_stb_o (bcast_stb_o),
      .bcast_mode_o(bcast_mode_o),
      .byte_o      (byte_o),
      .cmd_o       (cmd_o),
      .word_o      (word_o)
   );

   // R1: nothing is driven on the bus straight out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !sda_oe_o);
endmodule

// File: tb/test_smbus_wr_slave.sv
module test_smbus_wr_slave;
   localparam int CLK_P = 10;
   localparam int QTR   = 10;
   localparam logic [6:0] OWN = 7'h25;
   localparam logic [6:0] BC  = 7'h7E;

   typedef struct packed {
      logic [6:0]  addr;
      logic        rw;
      logic [2:0]  nb;
      logic [31:0] bytes;
      logic        rstart;
      logic [4:0]  ack;   // bit i: frame i acknowledged (0 = address)
      logic [4:0]  stb;   // cmd, lo, hi, bcast, stop
      logic        mode;
      logic [7:0]  cmd;
      logic [15:0] word;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      // R6 R8 full write word
      '{OWN, 1'b0, 3'd3, 32'h00123403, 1'b0, 5'b01111, 5'b11101, 1'b0, 8'h03, 16'h1234},
      // R7 send byte
      '{OWN, 1'b0, 3'd1, 32'h00000005, 1'b0, 5'b00011, 5'b10001, 1'b0, 8'h05, 16'h1234},
      // R8 stop after first data byte
      '{OWN, 1'b0, 3'd2, 32'h0000AB07, 1'b0, 5'b00111, 5'b11001, 1'b0, 8'h07, 16'h1234},
      // R4 foreign address, following bytes ignored
      '{7'h24, 1'b0, 3'd3, 32'h00776655, 1'b0, 5'b00000, 5'b00000, 1'b0, 8'h07, 16'h1234},
      // R2 own address with read flag
      '{OWN, 1'b1, 3'd0, 32'h0, 1'b0, 5'b00000, 5'b00000, 1'b0, 8'h07, 16'h1234},
      // R3 broadcast with mode 1
      '{BC, 1'b1, 3'd0, 32'h0, 1'b0, 5'b00001, 5'b00011, 1'b1, 8'h07, 16'h1234},
      // R3 broadcast with mode 0
      '{BC, 1'b0, 3'd0, 32'h0, 1'b0, 5'b00001, 5'b00011, 1'b0, 8'h07, 16'h1234},
      // R12 extra byte not acknowledged
      '{OWN, 1'b0, 3'd4, 32'h03020109, 1'b0, 5'b01111, 5'b11101, 1'b0, 8'h09, 16'h0201},
      // R8 R10 repeated start after first data byte
      '{OWN, 1'b0, 3'd2, 32'h0000CD0B, 1'b1, 5'b00111, 5'b11000, 1'b0, 8'h0B, 16'h0201},
      // R4 service after repeated start
      '{OWN, 1'b0, 3'd3, 32'h0022110D, 1'b0, 5'b01111, 5'b11101, 1'b0, 8'h0D, 16'h2211},
      // R2 quick command to own address
      '{OWN, 1'b0, 3'd0, 32'h0, 1'b0, 5'b00001, 5'b00001, 1'b0, 8'h0D, 16'h2211},
      // R2 neighbour address
      '{7'h20, 1'b0, 3'd1, 32'h00000099, 1'b0, 5'b00000, 5'b00000, 1'b0, 8'h0D, 16'h2211}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe, cmd_stb, lo_stb, hi_stb, stop_stb, bc_stb, bc_mode;
   logic [7:0] byte_v, cmd_v;
   logic [15:0] word_v;

   int total = 0;
   int bad = 0;
   int n_cmd = 0, n_lo = 0, n_hi = 0, n_bc = 0, n_stop = 0;
   int n_wide = 0, n_oe_hi = 0, n_conflict = 0;
   logic [7:0] last_lo = 8'h00;
   logic prev_any = 1'b0;
   logic prev_oe = 1'b0;
   bit done = 1'b0;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_P/2) clk = ~clk;

   smbus_wr_slave #(
      .SYNC_STAGES(2),
      .FILT_LEN   (3),
      .SEL_BITS   (3)
   ) i_smbus_wr_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_bus),
      .addr_sel_i  (3'b101),
      .sda_oe_o    (sda_oe),
      .cmd_stb_o   (cmd_stb),
      .lo_stb_o    (lo_stb),
      .hi_stb_o    (hi_stb),
      .stop_stb_o  (stop_stb),
      .bcast_stb_o (bc_stb),
      .bcast_mode_o(bc_mode),
      .byte_o      (byte_v),
      .cmd_o       (cmd_v),
      .word_o      (word_v)
   );

   always @(negedge clk) begin
      if (cmd_stb) n_cmd <= n_cmd + 1;
      if (lo_stb) begin
         n_lo    <= n_lo + 1;
         last_lo <= byte_v;
      end
      if (hi_stb)   n_hi   <= n_hi + 1;
      if (bc_stb)   n_bc   <= n_bc + 1;
      if (stop_stb) n_stop <= n_stop + 1;
      if (prev_any && (cmd_stb || lo_stb || hi_stb)) n_wide <= n_wide + 1;
      if (rst_n && (sda_oe != prev_oe) && scl_m) n_oe_hi <= n_oe_hi + 1;
      prev_any <= cmd_stb | lo_stb | hi_stb;
      prev_oe  <= sda_oe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR);
      sda_m = 1'b0; wait_clk(QTR);
      scl_m = 1'b0; wait_clk(QTR);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR);
      sda_m = 1'b1; wait_clk(2*QTR);
   endtask

   // one clock period; glitch pulls SCL low for two system clocks mid-high
   task automatic clk_bit(input logic b, input bit glitch, output logic seen);
      sda_m = b; wait_clk(QTR);
      scl_m = 1'b1; wait_clk(QTR/2);
      if (glitch) begin
         scl_m = 1'b0; wait_clk(2);
         scl_m = 1'b1; wait_clk(QTR/2 - 2);
      end else begin
         wait_clk(QTR/2);
      end
      seen = sda_bus;
      wait_clk(QTR);
      scl_m = 1'b0; wait_clk(QTR);
   endtask

   task automatic send_byte(input logic [7:0] b, input int gbit, output logic acked);
      logic seen;
      for (int k = 7; k >= 0; k--) begin
         clk_bit(b[k], (k == gbit), seen);
         if (b[k] && !seen) n_conflict++;
      end
      clk_bit(1'b1, 1'b0, seen);
      acked = ~seen;
   endtask

   task automatic run_row(input vec_t v, input int idx);
      int c0, l0, h0, b0, s0;
      logic [4:0] acks;
      logic a;
      c0 = n_cmd; l0 = n_lo; h0 = n_hi; b0 = n_bc; s0 = n_stop;
      acks = '0;
      bus_start();
      send_byte({v.addr, v.rw}, -1, a);
      acks[0] = a;
      for (int j = 0; j < int'(v.nb); j++) begin
         send_byte(v.bytes[8*j +: 8], -1, a);
         acks[j+1] = a;
      end
      if (!v.rstart) bus_stop();
      wait_clk(QTR);
      check(acks == v.ack, $sformatf("R2 acks row %0d", idx), acks, v.ack);
      check((n_cmd - c0) == int'(v.stb[4]) && (n_lo - l0) == int'(v.stb[3])
            && (n_hi - h0) == int'(v.stb[2]),
            $sformatf("R6 strobes row %0d", idx),
            {(n_cmd - c0), (n_lo - l0), (n_hi - h0)}, v.stb[4:2]);
      check((n_bc - b0) == int'(v.stb[1]), $sformatf("R3 bcast row %0d", idx),
            n_bc - b0, v.stb[1]);
      if (v.stb[1]) check(bc_mode == v.mode, $sformatf("R3 mode row %0d", idx), bc_mode, v.mode);
      check((n_stop - s0) == int'(v.stb[0]), $sformatf("R10 stop row %0d", idx),
            n_stop - s0, v.stb[0]);
      check(cmd_v == v.cmd, $sformatf("R7 cmd row %0d", idx), cmd_v, v.cmd);
      check(word_v == v.word, $sformatf("R8 word row %0d", idx), word_v, v.word);
   endtask

   initial begin
      int c0;
      logic a;
      wait_clk(5);
      // R1 reset state
      check(!sda_oe && !cmd_stb && !lo_stb && !hi_stb && !stop_stb && !bc_stb,
            "R1 outputs idle in reset", sda_oe, 0);
      rst_n = 1'b1;
      wait_clk(5);
      check(cmd_v == 8'h00 && word_v == 16'h0000, "R1 registers cleared",
            {cmd_v, word_v}, 0);

      for (int i = 0; i < NV; i++) run_row(TBL[i], i);

      // R9 STOP inside the command byte
      c0 = n_cmd;
      bus_start();
      send_byte({OWN, 1'b0}, -1, a);
      for (int k = 0; k < 4; k++) begin
         logic s;
         clk_bit(1'b1, 1'b0, s);
      end
      bus_stop();
      wait_clk(QTR);
      check(n_cmd == c0, "R9 no command strobe", n_cmd - c0, 0);
      check(cmd_v == 8'h0D, "R9 command kept", cmd_v, 8'h0D);

      // R9 repeated START inside the command byte, then a clean send byte
      bus_start();
      send_byte({OWN, 1'b0}, -1, a);
      for (int k = 0; k < 3; k++) begin
         logic s;
         clk_bit(1'b0, 1'b0, s);
      end
      bus_start();
      send_byte({OWN, 1'b0}, -1, a);
      send_byte(8'h11, -1, a);
      bus_stop();
      wait_clk(QTR);
      check(cmd_v == 8'h11, "R9 command after abort", cmd_v, 8'h11);

      // R11 short SCL glitch inside the first data byte
      bus_start();
      send_byte({OWN, 1'b0}, -1, a);
      send_byte(8'h0F, -1, a);
      send_byte(8'h5A, 4, a);
      check(a == 1'b1, "R11 glitched byte acked", a, 1);
      check(last_lo == 8'h5A, "R11 glitched byte value", last_lo, 8'h5A);
      send_byte(8'hA5, 6, a);
      bus_stop();
      wait_clk(QTR);
      check(word_v == 16'hA55A, "R11 word through glitches", word_v, 16'hA55A);

      check(n_oe_hi == 0, "R5 drive change while SCL high", n_oe_hi, 0);
      check(n_conflict == 0, "R5 drive outside acknowledge", n_conflict, 0);
      check(n_wide == 0, "R6 strobe wider than one cycle", n_wide, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_clk(150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule